// File: doc/BRIEF.md
# Chaining DMA Sequencer with Memory-Mapped Control

This block is the control core of a bus-mastering DMA engine. Software programs it through single-cycle register reads and writes: a control/status word, a PCI address counter, a byte counter, a write-only local SDRAM address and a read-only interrupt status word. A transfer is armed by writing the PCI address counter. For chained operation it is armed by a control write with the chain flag set, and the engine then pulls byte-count/address pairs from an external descriptor queue until that queue runs dry.

Once a transfer starts, the block pulses a master request and an SDRAM start together. It then counts one QWORD per transfer pulse from the data path, advancing both address counters and shrinking the byte count. If the master side ends a transaction early with bytes left, the engine waits until both the master and the SDRAM side report idle, then asks for a fresh transaction that covers the remainder. When the count is exhausted, or the chain has no more descriptors, it flags terminal count and can raise an interrupt. The PCI master core, the SDRAM controller and the descriptor storage sit outside the block.

Top module: `dma_chain_engine`

## Requirements
- R1: After reset every register reads zero, and irq, mstReq, sdramStart and descPop are low. Registers are decoded with regAddr[19]=0 at word offsets 0x00 control, 0x04 PCI address, 0x08 byte count, 0x0C interrupt status and 0x10 local address. The byte count holds bits 16:3 and reads zero elsewhere.
- R2: Control bits are: 0 interrupt enable, 1 flush, 3 direction (1 = SDRAM to PCI, driven on dirSdramToPci), 4 DMA enable, 5 completion-interrupt disable, 6 DMA-on (read-only status), 8 chain enable. Bits 1, 2 and 7 always read 0.
- R3: The PCI address register keeps bits 31:3 and reads 0 in bits 2:0. Writing it sets address-loaded, which is interrupt-status bit 4.
- R4: With DMA enable set, no error pending and address-loaded set, DMA-on reads 1 one cycle after the address write. In that same cycle mstReq and sdramStart are high for exactly one cycle.
- R5: While a transfer runs, each xferPulse adds 8 to the PCI address and to localAddr and subtracts 8 from the byte count.
- R6: When the byte count reaches zero, terminal count (status bit 3) and interrupt pending (bit 0) are set, and address-loaded, start-chain (bit 5) and DMA-on clear.
- R7: Terminal count and interrupt pending are cleared by a read of the status word, a control write or a PCI address write. A completion in the same cycle as a clear leaves them set.
- R8: irq (also status bit 2) is high exactly when interrupt enable is set and either error pending is set or terminal count is set with the completion-interrupt disable clear.
- R9: errPulse sets error pending (status bit 1) and errClear clears it; when both arrive together the bit stays set. While error pending is set no transfer starts.
- R10: An earlyTerm with bytes remaining holds off any new request until mstIdle and sdramIdle are both high, then issues one new mstReq/sdramStart for the remainder. If the last transfer pulse and earlyTerm coincide, the engine completes without a new request.
- R11: A control write with chain enable and DMA enable sets start-chain. The engine pops the byte count (first word, bits 16:3) and then the PCI address (second word, bits 31:3), starts, and fetches the next pair after each completion until the queue is empty. If the queue is already empty it completes at once.
- R12: A control write with the flush bit clears address-loaded, start-chain and DMA-on and stops the engine without setting terminal count; later transfer pulses are ignored.
- R13: Writes with regAddr[19]=1 (descriptor region) change no register, and reads there return 0; the local address register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWr | input | 1 | Single-cycle register write strobe |
| regRd | input | 1 | Single-cycle register read strobe (side effects only) |
| regAddr | input | 20 | Byte address within the block's window |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data for regAddr, combinational |
| descEmpty | input | 1 | Descriptor queue has no word available |
| descData | input | 32 | Head word of the descriptor queue |
| descPop | output | 1 | Consume the head descriptor word |
| mstReq | output | 1 | One-cycle request for a master transaction |
| sdramStart | output | 1 | One-cycle trigger for an SDRAM access |
| xferPulse | input | 1 | One QWORD moved |
| earlyTerm | input | 1 | Master transaction ended early |
| mstIdle | input | 1 | Master side is idle |
| sdramIdle | input | 1 | SDRAM side is idle |
| errPulse | input | 1 | Abort or parity error event |
| errClear | input | 1 | Clear error pending |
| irq | output | 1 | Interrupt request |
| dirSdramToPci | output | 1 | Transfer direction from the control word |
| pciAddr | output | 32 | Current PCI address |
| localAddr | output | 25 | Current local SDRAM address |

## Verification
Two pairs of events can land on the same clock edge. The first pair is completion and a clear of terminal count. The bench issues the last transfer pulse so that the completion edge falls on the same edge as a status read, and it expects terminal count to be set afterwards. The second pair is the final transfer pulse and an early termination. The bench raises both in one cycle with the master side busy, and it checks that terminal count appears two cycles later and that no new request is issued. Error set and clear arriving together is also driven, and the error bit must stay set.

// File: rtl/dma_chain_pkg.sv
package dma_chain_pkg;

  // Word indices of the register window (byte offset / 4).
  localparam int IDX_CSR = 0;
  localparam int IDX_ACR = 1;
  localparam int IDX_BCR = 2;
  localparam int IDX_ISR = 3;
  localparam int IDX_LAR = 4;

  // Control word bit positions.
  localparam int CSR_INT_EN = 0;
  localparam int CSR_FLUSH  = 1;
  localparam int CSR_DIR    = 3;
  localparam int CSR_EN     = 4;
  localparam int CSR_TC_DIS = 5;
  localparam int CSR_CHAIN  = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH_LEN,
    ST_FETCH_ADDR,
    ST_START,
    ST_XFER,
    ST_WAIT
  } seqState_e;

  // Strobes from sequencer to register datapath.
  typedef struct packed {
    logic setDmaOn;
    logic finish;
    logic popLen;
    logic popAddr;
    logic countStep;
  } seqStrobe_t;

  // Status from register datapath to sequencer.
  typedef struct packed {
    logic addrLoaded;
    logic startChain;
    logic dmaEn;
    logic errPending;
    logic bcntZero;
    logic flushHit;
    logic dmaOn;
  } regStatus_t;

endpackage

// File: rtl/dma_chain_regs.sv
module dma_chain_regs
  import dma_chain_pkg::*;
#(
  parameter int ADDR_QW_W  = 29,
  parameter int BCNT_QW_W  = 14,
  parameter int LADDR_QW_W = 22,
  parameter int REG_AW     = 20
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    regWr,
  input  logic                    regRd,
  input  logic [REG_AW-1:0]       regAddr,
  input  logic [31:0]             regWdata,
  output logic [31:0]             regRdata,
  input  logic [31:0]             descData,
  input  logic                    errPulse,
  input  logic                    errClear,
  input  seqStrobe_t              strobe,
  output regStatus_t              status,
  output logic                    irq,
  output logic                    dirSdramToPci,
  output logic [ADDR_QW_W+2:0]    pciAddr,
  output logic [LADDR_QW_W+2:0]   localAddr
);

  localparam int ACR_W = ADDR_QW_W + 3;
  localparam int BCR_W = BCNT_QW_W + 3;
  localparam int LAR_W = LADDR_QW_W + 3;
  localparam int IDX_W = REG_AW - 3;

  logic [IDX_W-1:0] wordIdx;
  logic inRegSpace;
  logic hitCsr, hitAcr, hitBcr, hitIsr, hitLar;
  logic wrCsr, wrAcr, wrBcr, wrLar, rdIsr, flushHit;

  logic intEn, dirBit, dmaEn, tcDis, chainEn, dmaOn;
  logic addrLoaded, startChain, termCount, intPending, errPending;
  logic [ADDR_QW_W-1:0]  acrQw;
  logic [BCNT_QW_W-1:0]  bcrQw;
  logic [LADDR_QW_W-1:0] larQw;
  logic bcntZero;

  assign inRegSpace = ~regAddr[REG_AW-1];
  assign wordIdx    = regAddr[REG_AW-2:2];
  assign hitCsr = inRegSpace && (wordIdx == IDX_W'(IDX_CSR));
  assign hitAcr = inRegSpace && (wordIdx == IDX_W'(IDX_ACR));
  assign hitBcr = inRegSpace && (wordIdx == IDX_W'(IDX_BCR));
  assign hitIsr = inRegSpace && (wordIdx == IDX_W'(IDX_ISR));
  assign hitLar = inRegSpace && (wordIdx == IDX_W'(IDX_LAR));

  assign wrCsr    = regWr && hitCsr;
  assign wrAcr    = regWr && hitAcr;
  assign wrBcr    = regWr && hitBcr;
  assign wrLar    = regWr && hitLar;
  assign rdIsr    = regRd && hitIsr;
  assign flushHit = wrCsr && regWdata[CSR_FLUSH];
  assign bcntZero = (bcrQw == '0);

  // Control fields written by software.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      intEn <= 1'b0; dirBit <= 1'b0; dmaEn <= 1'b0; tcDis <= 1'b0; chainEn <= 1'b0;
    end else if (wrCsr) begin
      intEn   <= regWdata[CSR_INT_EN];
      dirBit  <= regWdata[CSR_DIR];
      dmaEn   <= regWdata[CSR_EN];
      tcDis   <= regWdata[CSR_TC_DIS];
      chainEn <= regWdata[CSR_CHAIN];
    end
  end

  // Engine status bits: completion and flush win over arming.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      dmaOn <= 1'b0; addrLoaded <= 1'b0; startChain <= 1'b0;
      termCount <= 1'b0; intPending <= 1'b0; errPending <= 1'b0;
    end else begin
      if (flushHit || strobe.finish)   dmaOn <= 1'b0;
      else if (strobe.setDmaOn)        dmaOn <= 1'b1;

      if (flushHit || strobe.finish)   addrLoaded <= 1'b0;
      else if (wrAcr)                  addrLoaded <= 1'b1;

      if (flushHit || strobe.finish)   startChain <= 1'b0;
      else if (wrCsr && regWdata[CSR_CHAIN] && regWdata[CSR_EN]) startChain <= 1'b1;

      if (strobe.finish) begin
        termCount  <= 1'b1;
        intPending <= 1'b1;
      end else if (wrCsr || wrAcr || rdIsr) begin
        termCount  <= 1'b0;
        intPending <= 1'b0;
      end

      if (errPulse)      errPending <= 1'b1;
      else if (errClear) errPending <= 1'b0;
    end
  end

  // Counters over QWORD units.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      acrQw <= '0; bcrQw <= '0; larQw <= '0;
    end else begin
      if (wrAcr)               acrQw <= regWdata[ACR_W-1:3];
      else if (strobe.popAddr) acrQw <= descData[ACR_W-1:3];
      else if (strobe.countStep && !bcntZero) acrQw <= acrQw + ADDR_QW_W'(1);

      if (wrBcr)               bcrQw <= regWdata[BCR_W-1:3];
      else if (strobe.popLen)  bcrQw <= descData[BCR_W-1:3];
      else if (strobe.countStep && !bcntZero) bcrQw <= bcrQw - BCNT_QW_W'(1);

      if (wrLar)               larQw <= regWdata[LAR_W-1:3];
      else if (strobe.countStep && !bcntZero) larQw <= larQw + LADDR_QW_W'(1);
    end
  end

  assign irq = intEn && ((termCount && !tcDis) || errPending);

  always_comb begin
    regRdata = '0;
    if (hitCsr)      regRdata = 32'({chainEn, 1'b0, dmaOn, tcDis, dmaEn, dirBit, 2'b00, intEn});
    else if (hitAcr) regRdata = 32'({acrQw, 3'b000});
    else if (hitBcr) regRdata = 32'({bcrQw, 3'b000});
    else if (hitIsr) regRdata = 32'({startChain, addrLoaded, termCount, irq, errPending, intPending});
  end

  assign status = '{addrLoaded: addrLoaded, startChain: startChain, dmaEn: dmaEn,
                    errPending: errPending, bcntZero: bcntZero, flushHit: flushHit,
                    dmaOn: dmaOn};
  assign dirSdramToPci = dirBit;
  assign pciAddr       = {acrQw, 3'b000};
  assign localAddr     = {larQw, 3'b000};

  // R6: a completion strobe leaves terminal count and pending set, engine off
  p_finish_flags_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.finish |=> (termCount && intPending && !dmaOn && !addrLoaded));

  // R5: each counted step removes one QWORD from the byte count
  p_bcnt_step_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.countStep && !bcntZero && !wrBcr && !strobe.popLen)
      |=> (bcrQw == $past(bcrQw) - BCNT_QW_W'(1)));

  // R9: an error event always leaves error pending set
  p_err_set_r9: assert property (@(posedge clk) disable iff (!rstN)
    errPulse |=> errPending);

endmodule

// File: rtl/dma_chain_ctrl.sv
module dma_chain_ctrl
  import dma_chain_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  regStatus_t status,
  input  logic       descEmpty,
  input  logic       xferPulse,
  input  logic       earlyTerm,
  input  logic       mstIdle,
  input  logic       sdramIdle,
  output seqStrobe_t strobe,
  output logic       descPop,
  output logic       mstReq,
  output logic       sdramStart
);

  seqState_e state, stateNext;
  logic mayStart;

  assign mayStart = status.dmaEn && !status.errPending;

  always_comb begin
    stateNext = state;
    strobe    = '0;
    unique case (state)
      ST_IDLE: begin
        if (status.startChain && mayStart) begin
          if (descEmpty) strobe.finish = 1'b1;
          else begin
            strobe.setDmaOn = 1'b1;
            stateNext = ST_FETCH_LEN;
          end
        end else if (status.addrLoaded && mayStart) begin
          strobe.setDmaOn = 1'b1;
          stateNext = ST_START;
        end
      end
      ST_FETCH_LEN: if (!descEmpty) begin
        strobe.popLen = 1'b1;
        stateNext = ST_FETCH_ADDR;
      end
      ST_FETCH_ADDR: if (!descEmpty) begin
        strobe.popAddr = 1'b1;
        stateNext = ST_START;
      end
      ST_START: stateNext = ST_XFER;
      ST_XFER: begin
        strobe.countStep = xferPulse;
        if (status.bcntZero) begin
          if (status.startChain && !descEmpty) stateNext = ST_FETCH_LEN;
          else begin
            strobe.finish = 1'b1;
            stateNext = ST_IDLE;
          end
        end else if (earlyTerm) stateNext = ST_WAIT;
      end
      ST_WAIT: begin
        if (status.bcntZero) begin
          if (status.startChain && !descEmpty) stateNext = ST_FETCH_LEN;
          else begin
            strobe.finish = 1'b1;
            stateNext = ST_IDLE;
          end
        end else if (mstIdle && sdramIdle) stateNext = ST_START;
      end
      default: stateNext = ST_IDLE;
    endcase
    if (status.flushHit) begin
      strobe    = '0;
      stateNext = ST_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign descPop    = strobe.popLen || strobe.popAddr;
  assign mstReq     = (state == ST_START);
  assign sdramStart = (state == ST_START);

  // R11: the queue is never popped while empty
  p_pop_nonempty_r11: assert property (@(posedge clk) disable iff (!rstN)
    descPop |-> !descEmpty);

  // R4: a request only goes out while the datapath reports DMA-on
  p_req_dmaon_r4: assert property (@(posedge clk) disable iff (!rstN)
    mstReq |-> status.dmaOn);

  // R4: an armed, enabled, error-free engine turns on one cycle later
  p_arm_start_r4: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && status.addrLoaded && status.dmaEn && !status.errPending &&
     !status.startChain && !status.flushHit) |=> status.dmaOn);

  // R9: nothing starts while an error is pending
  p_err_blocks_r9: assert property (@(posedge clk) disable iff (!rstN)
    status.errPending |-> !strobe.setDmaOn);

  // R10: no new request while either side still reports busy
  p_wait_idle_r10: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT && !(mstIdle && sdramIdle)) |=> !mstReq);

endmodule

// File: rtl/dma_chain_engine.sv
module dma_chain_engine
  import dma_chain_pkg::*;
#(
  parameter int ADDR_QW_W  = 29,
  parameter int BCNT_QW_W  = 14,
  parameter int LADDR_QW_W = 22,
  parameter int REG_AW     = 20
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  regWr,
  input  logic                  regRd,
  input  logic [REG_AW-1:0]     regAddr,
  input  logic [31:0]           regWdata,
  output logic [31:0]           regRdata,
  input  logic                  descEmpty,
  input  logic [31:0]           descData,
  output logic                  descPop,
  output logic                  mstReq,
  output logic                  sdramStart,
  input  logic                  xferPulse,
  input  logic                  earlyTerm,
  input  logic                  mstIdle,
  input  logic                  sdramIdle,
  input  logic                  errPulse,
  input  logic                  errClear,
  output logic                  irq,
  output logic                  dirSdramToPci,
  output logic [ADDR_QW_W+2:0]  pciAddr,
  output logic [LADDR_QW_W+2:0] localAddr
);

  seqStrobe_t strobe;
  regStatus_t status;

  dma_chain_regs #(
    .ADDR_QW_W(ADDR_QW_W), .BCNT_QW_W(BCNT_QW_W),
    .LADDR_QW_W(LADDR_QW_W), .REG_AW(REG_AW)
  ) uRegs (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regRd(regRd), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .descData(descData),
    .errPulse(errPulse), .errClear(errClear), .strobe(strobe), .status(status),
    .irq(irq), .dirSdramToPci(dirSdramToPci), .pciAddr(pciAddr), .localAddr(localAddr)
  );

  dma_chain_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .status(status), .descEmpty(descEmpty),
    .xferPulse(xferPulse), .earlyTerm(earlyTerm), .mstIdle(mstIdle),
    .sdramIdle(sdramIdle), .strobe(strobe), .descPop(descPop),
    .mstReq(mstReq), .sdramStart(sdramStart)
  );

endmodule

// File: tb/dma_chain_engine_test.sv
module dma_chain_engine_test;

  localparam logic [19:0] A_CSR = 20'h00000;
  localparam logic [19:0] A_ACR = 20'h00004;
  localparam logic [19:0] A_BCR = 20'h00008;
  localparam logic [19:0] A_ISR = 20'h0000C;
  localparam logic [19:0] A_LAR = 20'h00010;

  typedef struct packed {
    logic        isWr;
    logic [19:0] addr;
    logic [31:0] data;
    logic [31:0] exp;
  } vec_t;

  localparam int NVEC = 20;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, A_CSR, 32'h0, 32'h0},                // R1 reset
    '{1'b0, A_ACR, 32'h0, 32'h0},                // R1
    '{1'b0, A_BCR, 32'h0, 32'h0},                // R1
    '{1'b0, A_ISR, 32'h0, 32'h0},                // R1
    '{1'b1, A_CSR, 32'h0AF, 32'h0},
    '{1'b0, A_CSR, 32'h0, 32'h029},              // R2 reserved/flush read 0
    '{1'b1, A_ACR, 32'h1234567F, 32'h0},
    '{1'b0, A_ACR, 32'h0, 32'h12345678},         // R3 low bits zero
    '{1'b0, A_ISR, 32'h0, 32'h10},               // R3 address-loaded
    '{1'b1, A_BCR, 32'hFFFFFFFF, 32'h0},
    '{1'b0, A_BCR, 32'h0, 32'h0001FFF8},         // R1 byte count field
    '{1'b1, A_LAR, 32'h55, 32'h0},
    '{1'b0, A_LAR, 32'h0, 32'h0},                // R13 write-only
    '{1'b1, 20'h80000, 32'hDEADBEEF, 32'h0},
    '{1'b0, A_ACR, 32'h0, 32'h12345678},         // R13 queue write ignored
    '{1'b0, 20'h80004, 32'h0, 32'h0},            // R13 queue read zero
    '{1'b1, A_CSR, 32'h002, 32'h0},
    '{1'b0, A_CSR, 32'h0, 32'h0},                // R12 flush self-clears
    '{1'b0, A_ISR, 32'h0, 32'h0},                // R12 address-loaded gone
    '{1'b1, A_BCR, 32'h0, 32'h0}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWr = 1'b0, regRd = 1'b0;
  logic [19:0] regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic descEmpty, descPop;
  logic [31:0] descData;
  logic mstReq, sdramStart;
  logic xferPulse = 1'b0, earlyTerm = 1'b0;
  logic mstIdle = 1'b1, sdramIdle = 1'b1;
  logic errPulse = 1'b0, errClear = 1'b0;
  logic irq, dirSdramToPci;
  logic [31:0] pciAddr;
  logic [24:0] localAddr;

  logic [31:0] descQ [16];
  int descIdx = 0;
  int descCnt = 0;
  int nChecks = 0;
  int nFails = 0;

  always #4 clk = ~clk;

  always @(posedge clk) if (descPop) descIdx <= descIdx + 1;
  assign descEmpty = (descIdx >= descCnt);
  assign descData  = descQ[descIdx[3:0]];

  dma_chain_engine uut (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regRd(regRd), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .descEmpty(descEmpty),
    .descData(descData), .descPop(descPop), .mstReq(mstReq), .sdramStart(sdramStart),
    .xferPulse(xferPulse), .earlyTerm(earlyTerm), .mstIdle(mstIdle),
    .sdramIdle(sdramIdle), .errPulse(errPulse), .errClear(errClear), .irq(irq),
    .dirSdramToPci(dirSdramToPci), .pciAddr(pciAddr), .localAddr(localAddr)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [19:0] a, input logic [31:0] d);
    @(negedge clk);
    regWr = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic rd(input logic [19:0] a, output logic [31:0] v);
    @(negedge clk);
    regRd = 1'b1; regAddr = a;
    #1 v = regRdata;
    @(negedge clk);
    regRd = 1'b0;
  endtask

  task automatic peek(input logic [19:0] a, output logic [31:0] v);
    regAddr = a;
    #1 v = regRdata;
  endtask

  task automatic pulse();
    xferPulse = 1'b1;
    @(negedge clk);
    xferPulse = 1'b0;
  endtask

  task automatic waitReq(output logic seen);
    seen = 1'b0;
    for (int i = 0; i < 20 && !seen; i++) begin
      @(negedge clk);
      if (mstReq) seen = 1'b1;
    end
  endtask

  initial begin
    #(8 * 150000);
    nFails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic seen, anyReq;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset outputs
    check("R1 irq", 32'(irq), 32'h0);
    check("R1 mstReq", 32'(mstReq), 32'h0);
    check("R1 descPop", 32'(descPop), 32'h0);

    for (int i = 0; i < NVEC; i++) begin
      if (VECS[i].isWr) wr(VECS[i].addr, VECS[i].data);
      else begin
        rd(VECS[i].addr, v);
        check($sformatf("R1/R2/R3/R12/R13 vector %0d", i), v, VECS[i].exp);
      end
    end
    check("R13 localAddr after write", 32'(localAddr), 32'h50);

    // R2 direction pin
    wr(A_CSR, 32'h008);
    check("R2 direction", 32'(dirSdramToPci), 32'h1);
    wr(A_CSR, 32'h000);

    // R4/R5/R6: plain transfer of 3 QWORDs
    wr(A_LAR, 32'h100);
    wr(A_BCR, 32'h18);
    wr(A_CSR, 32'h11);
    wr(A_ACR, 32'h1000);
    peek(A_ISR, v); check("R3 armed", v, 32'h10);
    peek(A_CSR, v); check("R4 not yet on", v, 32'h11);
    check("R4 no early req", 32'(mstReq), 32'h0);
    @(negedge clk);
    peek(A_CSR, v); check("R4 dma on", v, 32'h51);
    check("R4 mstReq", 32'(mstReq), 32'h1);
    check("R4 sdramStart", 32'(sdramStart), 32'h1);
    @(negedge clk);
    check("R4 single pulse", 32'(mstReq), 32'h0);
    pulse();
    check("R5 pci addr", pciAddr, 32'h1008);
    peek(A_BCR, v); check("R5 byte count", v, 32'h10);
    check("R5 local addr", 32'(localAddr), 32'h108);
    pulse(); pulse();
    @(negedge clk);
    peek(A_ISR, v); check("R6 done status", v, 32'h0D);
    peek(A_CSR, v); check("R6 dma off", v, 32'h11);
    check("R8 irq on tc", 32'(irq), 32'h1);
    rd(A_ISR, v);
    peek(A_ISR, v); check("R7 read clears", v, 32'h0);
    check("R8 irq off", 32'(irq), 32'h0);

    // R8: completion interrupt disabled, error still interrupts
    wr(A_CSR, 32'h31);
    wr(A_ACR, 32'h0);
    repeat (4) @(negedge clk);
    peek(A_ISR, v); check("R8 tc masked", v, 32'h09);
    errPulse = 1'b1; @(negedge clk); errPulse = 1'b0;
    peek(A_ISR, v); check("R9 err sets", v, 32'h0F);
    check("R8 irq on err", 32'(irq), 32'h1);
    errClear = 1'b1; @(negedge clk); errClear = 1'b0;
    peek(A_ISR, v); check("R9 err clears", v, 32'h09);

    // R9: error blocks start; set beats clear
    errPulse = 1'b1; @(negedge clk); errPulse = 1'b0;
    wr(A_ACR, 32'h0);
    anyReq = 1'b0;
    for (int i = 0; i < 4; i++) begin @(negedge clk); anyReq |= mstReq; end
    peek(A_ISR, v); check("R9 blocked start", v, 32'h16);
    check("R9 no request", 32'(anyReq), 32'h0);
    errPulse = 1'b1; errClear = 1'b1; @(negedge clk); errPulse = 1'b0; errClear = 1'b0;
    peek(A_ISR, v); check("R9 set wins", 32'(v[1]), 32'h1);
    errClear = 1'b1; @(negedge clk); errClear = 1'b0;
    repeat (5) @(negedge clk);
    peek(A_ISR, v); check("R9 runs after clear", v, 32'h09);

    // R7: completion collides with status read
    wr(A_CSR, 32'h11);
    wr(A_BCR, 32'h8);
    wr(A_ACR, 32'h4000);
    repeat (2) @(negedge clk);
    xferPulse = 1'b1;
    @(negedge clk);
    xferPulse = 1'b0; regRd = 1'b1; regAddr = A_ISR;
    @(negedge clk);
    regRd = 1'b0;
    peek(A_ISR, v); check("R7 set wins over read", v, 32'h0D);
    wr(A_ACR, 32'h5000);
    peek(A_ISR, v); check("R7 address write clears", v, 32'h10);
    repeat (4) @(negedge clk);
    wr(A_CSR, 32'h11);
    peek(A_ISR, v); check("R7 control write clears", v, 32'h0);

    // R10: early termination, wait for both sides idle
    wr(A_BCR, 32'h20);
    wr(A_ACR, 32'h6000);
    repeat (2) @(negedge clk);
    pulse();
    mstIdle = 1'b0; sdramIdle = 1'b0; earlyTerm = 1'b1;
    @(negedge clk); earlyTerm = 1'b0;
    anyReq = 1'b0;
    for (int i = 0; i < 3; i++) begin @(negedge clk); anyReq |= mstReq; end
    mstIdle = 1'b1;
    for (int i = 0; i < 3; i++) begin @(negedge clk); anyReq |= mstReq; end
    check("R10 held while busy", 32'(anyReq), 32'h0);
    peek(A_BCR, v); check("R10 remainder", v, 32'h18);
    peek(A_CSR, v); check("R10 still on", v, 32'h51);
    sdramIdle = 1'b1;
    @(negedge clk);
    check("R10 re-request", 32'(mstReq), 32'h1);
    @(negedge clk);
    pulse(); pulse(); pulse();
    @(negedge clk);
    peek(A_ISR, v); check("R10 remainder done", v, 32'h0D);
    check("R10 final address", pciAddr, 32'h6020);

    // R10: last pulse and early termination together
    wr(A_CSR, 32'h11);
    wr(A_BCR, 32'h8);
    wr(A_ACR, 32'h7000);
    repeat (2) @(negedge clk);
    mstIdle = 1'b0; xferPulse = 1'b1; earlyTerm = 1'b1;
    @(negedge clk); xferPulse = 1'b0; earlyTerm = 1'b0;
    anyReq = 1'b0;
    @(negedge clk); anyReq |= mstReq;
    peek(A_ISR, v); check("R10 collision completes", v, 32'h0D);
    @(negedge clk); anyReq |= mstReq;
    check("R10 collision no request", 32'(anyReq), 32'h0);
    mstIdle = 1'b1;

    // R11: two-descriptor chain
    wr(A_CSR, 32'h11);
    descQ[descIdx]   = 32'h10;   descQ[descIdx+1] = 32'h2000;
    descQ[descIdx+2] = 32'h08;   descQ[descIdx+3] = 32'h3000;
    descCnt = descIdx + 4;
    wr(A_CSR, 32'h111);
    waitReq(seen);
    check("R11 first request", 32'(seen), 32'h1);
    check("R11 first address", pciAddr, 32'h2000);
    peek(A_BCR, v); check("R11 first count", v, 32'h10);
    peek(A_ISR, v); check("R11 chain flag", v, 32'h20);
    @(negedge clk);
    pulse(); pulse();
    waitReq(seen);
    check("R11 second request", 32'(seen), 32'h1);
    check("R11 second address", pciAddr, 32'h3000);
    peek(A_BCR, v); check("R11 second count", v, 32'h8);
    @(negedge clk);
    pulse();
    repeat (3) @(negedge clk);
    peek(A_ISR, v); check("R11 chain done", v, 32'h0D);
    check("R11 queue drained", 32'(descEmpty), 32'h1);

    // R11: empty queue completes at once
    wr(A_CSR, 32'h11);
    wr(A_CSR, 32'h111);
    @(negedge clk);
    peek(A_ISR, v); check("R11 empty chain", v, 32'h0D);

    // R12: flush mid-transfer
    wr(A_CSR, 32'h11);
    wr(A_BCR, 32'h40);
    wr(A_ACR, 32'h8000);
    repeat (2) @(negedge clk);
    pulse();
    wr(A_CSR, 32'h12);
    peek(A_CSR, v); check("R12 flush stops", v, 32'h10);
    peek(A_ISR, v); check("R12 no tc", v, 32'h0);
    pulse();
    anyReq = 1'b0;
    for (int i = 0; i < 3; i++) begin @(negedge clk); anyReq |= mstReq; end
    peek(A_BCR, v); check("R12 pulses ignored", v, 32'h38);
    check("R12 no request", 32'(anyReq), 32'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule